// File: doc/BRIEF.md
# Dual-Channel Serial Gain Register Controller

This block keeps the gain codes for two programmable-gain channels and updates them through a single narrow control port. The port has a serial clock, an enable, a data line, a mode line and a channel-select line. The block samples all of them with its own system clock, so the serial clock does not need to be related to that clock. Each channel has a 6-bit gain register, and its code drives that channel's amplifier. A 6-bit code covers 63 equal gain steps, from about 1 dB to about 34 dB.

The mode line picks one of two update methods. With the mode line low, the block shifts in a word one bit at a time. The word goes into the selected channel's register only when the enable drops, so the output gain never shows a half-loaded value. With the mode line high, the block steps the selected register by one code on each serial clock rise while the enable is high. The data line sets the direction of the step, and the code stops at either end of its range. The channel is chosen when the enable rises.

Each channel also has a separate amplifier power-down output. It follows a request input, so a channel can run in converter-only mode.

Top module: `sgc_dual_gain`

## Requirements
- R1: While reset is asserted, and directly after it is released, both gain outputs are 0 and amp_off is 2'b00.
- R2: With smode=0 (shift-load), sdata is captured on each rising sclk while sen=1, MSB first. When sen falls after at least six bits, the six most recently captured bits become the gain of the selected channel.
- R3: During shift-load, the gain outputs do not change while bits are being shifted in. They change only when sen falls.
- R4: If sen falls in shift-load mode after fewer than six bits, the word is discarded and both gains stay unchanged.
- R5: With smode=1 (tracking), each rising sclk while sen=1 changes the selected gain by exactly one code. It goes up when sdata=1 and down when sdata=0.
- R6: In tracking mode the gain saturates: it stays at 63 when stepping up and at 0 when stepping down.
- R7: chsel is sampled when sen rises: 0 selects gain0 and 1 selects gain1. The other channel is never touched, and a change of chsel during the transaction has no effect.
- R8: Rising edges of sclk while sen=0 leave both gains unchanged in either mode.
- R9: amp_off[i] follows amp_dis_req[i], with bit 0 for channel 0 and bit 1 for channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the control port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock; its rising edges are the events |
| sen | input | 1 | Transaction enable, active high |
| sdata | input | 1 | Serial data bit, or the step direction in tracking mode (1 = up) |
| smode | input | 1 | Update method: 0 = shift-load, 1 = tracking |
| chsel | input | 1 | Target channel, sampled when sen rises |
| amp_dis_req | input | 2 | Per-channel amplifier power-down request |
| gain0 | output | 6 | Gain code of channel 0 |
| gain1 | output | 6 | Gain code of channel 1 |
| amp_off | output | 2 | Per-channel amplifier power-down |

## Verification
Every control input passes through a two-stage synchronizer. An edge detector then compares the synchronized value with its delayed copy. As a result, a gain update caused by an sclk or sen edge shows on the outputs at the third rising clk edge after the input changed. amp_off shows the request at the second rising edge. The bench changes inputs on falling clk edges and holds each level for four clock cycles. It samples results on a falling edge after that hold, which is always later than the due edge. To show that the gain holds steady during shifting, the bench samples after every single bit, not only at the end of the word.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  parameter int unsigned SGC_NCH = 2;

  typedef enum logic {
    UPD_SHIFT = 1'b0,
    UPD_TRACK = 1'b1
  } upd_mode_e;

endpackage

// File: rtl/sgc_rst_sync.sv
module sgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int i = 0; i < int'(STAGES); i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sgc_front.sv
module sgc_front
  import sgc_pkg::*;
#(
  parameter int unsigned GAIN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_sn,
  input  logic                  sclk_s,
  input  logic                  sen_s,
  input  logic                  sdata_s,
  input  logic                  smode_s,
  input  logic                  chsel_s,
  output logic [SGC_NCH-1:0]    load_v,
  output logic [GAIN_W-1:0]     load_word,
  output logic [SGC_NCH-1:0]    step_v,
  output logic                  step_up
);

  localparam int unsigned CNT_W = $clog2(GAIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GAIN_W);

  logic              sclk_d_q, sen_d_q, ch_q;
  logic [GAIN_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sclk_rise, sen_rise, sen_fall;
  logic              ch_eff, shift_en, track_ev, commit;
  logic              ch_en, cnt_en;
  upd_mode_e         mode;

  assign mode      = upd_mode_e'(smode_s);
  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sen_rise  = sen_s & ~sen_d_q;
  assign sen_fall  = ~sen_s & sen_d_q;
  assign ch_eff    = sen_rise ? chsel_s : ch_q;
  assign shift_en  = sen_s & sclk_rise & (mode == UPD_SHIFT);
  assign track_ev  = sen_s & sclk_rise & (mode == UPD_TRACK);
  assign commit    = sen_fall & (mode == UPD_SHIFT) & (cnt_q == CNT_FULL);
  assign ch_en     = sen_rise;
  assign cnt_en    = sen_rise | shift_en;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = sen_rise ? '0 : cnt_q;
    if (shift_en) begin
      sh_n = {sh_q[GAIN_W-2:0], sdata_s};
      if (cnt_n != CNT_FULL) begin
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_d_q <= 1'b0;
      sen_d_q  <= 1'b0;
      ch_q     <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      sen_d_q  <= sen_s;
      if (ch_en)    ch_q  <= chsel_s;
      if (shift_en) sh_q  <= sh_n;
      if (cnt_en)   cnt_q <= cnt_n;
    end
  end

  always_comb begin
    load_v = '0;
    step_v = '0;
    if (commit)   load_v[ch_q]   = 1'b1;
    if (track_ev) step_v[ch_eff] = 1'b1;
  end

  assign load_word = sh_q;
  assign step_up   = sdata_s;

endmodule

// File: rtl/sgc_gain_reg.sv
module sgc_gain_reg #(
  parameter int unsigned GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              load,
  input  logic [GAIN_W-1:0] word,
  input  logic              step,
  input  logic              up,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_MIN = '0;

  logic [GAIN_W-1:0] gain_q, gain_n;
  logic              gain_en;

  assign gain_en = load | step;

  always_comb begin
    gain_n = gain_q;
    if (load) begin
      gain_n = word;
    end else if (step) begin
      if (up) begin
        if (gain_q != G_MAX) gain_n = gain_q + 1'b1;
      end else begin
        if (gain_q != G_MIN) gain_n = gain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gain_q <= '0;
    end else if (gain_en) begin
      gain_q <= gain_n;
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/sgc_dual_gain.sv
module sgc_dual_gain
  import sgc_pkg::*;
#(
  parameter int unsigned GAIN_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen,
  input  logic              sdata,
  input  logic              smode,
  input  logic              chsel,
  input  logic [1:0]        amp_dis_req,
  output logic [GAIN_W-1:0] gain0,
  output logic [GAIN_W-1:0] gain1,
  output logic [1:0]        amp_off
);

  localparam int unsigned IN_W = 5 + SGC_NCH;

  logic                          rst_sn;
  logic [IN_W-1:0]               raw_in, syn_in;
  logic [SGC_NCH-1:0]            load_v, step_v;
  logic [GAIN_W-1:0]             load_word;
  logic                          step_up;
  logic [SGC_NCH-1:0][GAIN_W-1:0] gain_q;

  sgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign raw_in = {amp_dis_req, chsel, smode, sdata, sen, sclk};

  sgc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_sn (rst_sn),
    .d      (raw_in),
    .q      (syn_in)
  );

  sgc_front #(.GAIN_W(GAIN_W)) u_front (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sclk_s    (syn_in[0]),
    .sen_s     (syn_in[1]),
    .sdata_s   (syn_in[2]),
    .smode_s   (syn_in[3]),
    .chsel_s   (syn_in[4]),
    .load_v    (load_v),
    .load_word (load_word),
    .step_v    (step_v),
    .step_up   (step_up)
  );

  for (genvar c = 0; c < SGC_NCH; c++) begin : g_ch
    sgc_gain_reg #(.GAIN_W(GAIN_W)) u_reg (
      .clk    (clk),
      .rst_sn (rst_sn),
      .load   (load_v[c]),
      .word   (load_word),
      .step   (step_v[c]),
      .up     (step_up),
      .gain   (gain_q[c])
    );
  end

  assign gain0   = gain_q[0];
  assign gain1   = gain_q[1];
  assign amp_off = syn_in[IN_W-1:5];

endmodule

// File: rtl/sgc_dual_gain_chk.sv
module sgc_dual_gain_chk #(
  parameter int unsigned GAIN_W = 6
) (
  input logic                   clk,
  input logic                   rst_sn,
  input logic [1:0]             load_v,
  input logic [1:0]             step_v,
  input logic                   step_up,
  input logic [1:0][GAIN_W-1:0] gain_q
);

  localparam logic [GAIN_W-1:0] G_MAX = '1;

  p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({load_v, step_v}));

  for (genvar c = 0; c < 2; c++) begin : g_c
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
      (!load_v[c] && !step_v[c]) |=> $stable(gain_q[c]));

    p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_sn)
      (step_v[c] && step_up && gain_q[c] != G_MAX) |=> (gain_q[c] == $past(gain_q[c]) + 1'b1));

    p_step_dn_r5: assert property (@(posedge clk) disable iff (!rst_sn)
      (step_v[c] && !step_up && gain_q[c] != '0) |=> (gain_q[c] == $past(gain_q[c]) - 1'b1));

    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_sn)
      (step_v[c] && step_up && gain_q[c] == G_MAX) |=> (gain_q[c] == G_MAX));

    p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_sn)
      (step_v[c] && !step_up && gain_q[c] == '0) |=> (gain_q[c] == '0));
  end

endmodule

bind sgc_dual_gain sgc_dual_gain_chk #(.GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/sim_sgc_dual_gain.sv
module sim_sgc_dual_gain;

  logic       clk = 1'b0;
  logic       rst_n, sclk, sen, sdata, smode, chsel;
  logic [1:0] amp_dis_req;
  logic [5:0] gain0, gain1;
  logic [1:0] amp_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sgc_dual_gain u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen(sen), .sdata(sdata),
    .smode(smode), .chsel(chsel), .amp_dis_req(amp_dis_req),
    .gain0(gain0), .gain1(gain1), .amp_off(amp_off)
  );

  // fields: req[31:28] kind[27] ch[26] count[25:20] data[19:12] exp0[11:6] exp1[5:0]
  localparam logic [31:0] VEC [9] = '{
    {4'd2, 1'b0, 1'b0, 6'd6,  8'h2A,       6'd42, 6'd0 },  // R2 load ch0
    {4'd7, 1'b0, 1'b1, 6'd6,  8'h15,       6'd42, 6'd21},  // R7 load ch1 only
    {4'd5, 1'b1, 1'b0, 6'd3,  8'h01,       6'd45, 6'd21},  // R5 up 3
    {4'd5, 1'b1, 1'b1, 6'd5,  8'h00,       6'd45, 6'd16},  // R5 down 5
    {4'd4, 1'b0, 1'b0, 6'd4,  8'h03,       6'd45, 6'd16},  // R4 partial
    {4'd2, 1'b0, 1'b1, 6'd8,  8'b10110011, 6'd45, 6'd51},  // R2 last six of eight
    {4'd6, 1'b1, 1'b0, 6'd25, 8'h01,       6'd63, 6'd51},  // R6 top
    {4'd6, 1'b1, 1'b1, 6'd60, 8'h00,       6'd63, 6'd0 },  // R6 bottom
    {4'd2, 1'b0, 1'b1, 6'd6,  8'h3F,       6'd63, 6'd63}   // R2 all ones
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; hold(4);
    sclk = 1'b0; hold(4);
  endtask

  task automatic open_txn(input logic m, input logic ch);
    smode = m; chsel = ch; hold(4);
    sen = 1'b1; hold(4);
  endtask

  task automatic close_txn();
    sen = 1'b0; hold(4);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sen = 1'b0; sdata = 1'b0;
    smode = 1'b0; chsel = 1'b0; amp_dis_req = 2'b00;
    hold(3);
    chk("R1", gain0, 6'd0);
    chk("R1", gain1, 6'd0);
    rst_n = 1'b1; hold(4);
    chk("R1", {4'd0, amp_off}, 6'd0);

    for (int v = 0; v < 9; v++) begin
      logic [31:0] e;
      string rq;
      e = VEC[v];
      rq = $sformatf("R%0d", e[31:28]);
      open_txn(e[27], e[26]);
      if (e[27] == 1'b0) begin
        for (int b = int'(e[25:20]) - 1; b >= 0; b--) begin
          sdata = e[12 + b]; hold(4);
          pulse_sclk();
        end
      end else begin
        sdata = e[12]; hold(4);
        for (int s = 0; s < int'(e[25:20]); s++) pulse_sclk();
      end
      close_txn();
      chk(rq, gain0, e[11:6]);
      chk(rq, gain1, e[5:0]);
    end

    // R3: gain0 holds 63 while 000001 shifts in, then takes 1
    open_txn(1'b0, 1'b0);
    for (int b = 5; b >= 0; b--) begin
      sdata = (b == 0); hold(4);
      pulse_sclk();
      chk("R3", gain0, 6'd63);
    end
    close_txn();
    chk("R3", gain0, 6'd1);

    // R8: sclk with sen low, both modes
    smode = 1'b1; sdata = 1'b1; hold(4);
    pulse_sclk(); pulse_sclk();
    smode = 1'b0; hold(4);
    pulse_sclk();
    chk("R8", gain0, 6'd1);
    chk("R8", gain1, 6'd63);

    // R7: chsel changed mid-transaction is ignored
    open_txn(1'b1, 1'b1);
    chsel = 1'b0; sdata = 1'b0; hold(4);
    pulse_sclk(); pulse_sclk(); pulse_sclk();
    close_txn();
    chk("R7", gain0, 6'd1);
    chk("R7", gain1, 6'd60);

    // R9: amplifier power-down per channel
    amp_dis_req = 2'b10; hold(4);
    chk("R9", {4'd0, amp_off}, 6'd2);
    amp_dis_req = 2'b01; hold(4);
    chk("R9", {4'd0, amp_off}, 6'd1);

    // R1: reset after activity
    amp_dis_req = 2'b00; hold(4);
    rst_n = 1'b0; hold(2);
    chk("R1", gain0, 6'd0);
    chk("R1", gain1, 6'd0);
    rst_n = 1'b1; hold(4);
    chk("R1", gain1, 6'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule